// File: doc/BRIEF.md
# Selectable Clock Divider with Half-Rate Companion Output

This block turns one input clock into two related output clocks. A 2-bit select picks what the primary output carries: the input divided by an odd ratio (three or five by default), a supplied doubled clock, or nothing at all (power-down). The secondary output always runs at half the primary's rate. It changes state only on primary rising edges, so the two stay phase-locked. An output enable releases both pins to high impedance when it is low, whatever the select or power state.

Odd ratios still give a near-symmetric waveform. A counter on the input's rising edge makes a high window of floor(N/2) input cycles. A copy of that window, delayed by half a cycle on the falling edge, is OR-ed onto it, which stretches the high time to exactly N/2 input cycles. A small controller sequences the modes. Its states are `ST_OFF` (power-down, counters held clear), `ST_RESTART` (one cycle of counter clear after a select change), `ST_RUN_DIV` (odd/even divider running) and `ST_RUN_DBL` (primary gated from the doubled clock). Its transitions are:
- Sleep: any state goes to `ST_OFF` while the select is 00.
- Reload: any state goes to `ST_RESTART` when a non-zero select differs from the code registered on the previous edge.
- Launch-divide: `ST_RESTART` goes to `ST_RUN_DIV`.
- Launch-double: `ST_RESTART` goes to `ST_RUN_DBL` when the code is 01.

The run states hold while the select is steady.

Top module: `clkdiv_pair`

## Requirements
- R1: With select 2'b11 the primary output has a period of DIV_FAST (default 3) input cycles and is high for DIV_FAST/2 input cycles (3 half-cycles by default).
- R2: With select 2'b10 the primary output has a period of DIV_SLOW (default 5) input cycles and is high for DIV_SLOW/2 input cycles (5 half-cycles by default).
- R3: In every running mode the secondary output has twice the primary period and is high for exactly one primary period.
- R4: Every transition of the secondary output occurs at the same instant as a rising edge of the primary output.
- R5: With select 2'b01 the primary output reproduces `clk_2x_in` (half the input period, high for a quarter input period) and the secondary output runs at the input frequency.
- R6: With select 2'b00, within three input cycles both outputs are low and they stay low with no toggling; leaving 2'b00 resumes the selected ratio.
- R7: While `oe` is low both outputs are high impedance, in running and power-down modes alike; raising `oe` again restores the running clocks.
- R8: A change between non-zero select codes clears the divider counter within two input cycles. No primary high or low pulse during the change is shorter than one input half-period.
- R9: Asserting `rst_n` low drives both outputs low at once, without waiting for a clock edge, and clears the counters.
- R10: In the odd divide modes the falling-edge stretch stage copies the rising-edge high window half a cycle later. This keeps the primary duty cycle within 45% to 55%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| clk_2x_in | input | 1 | Doubled clock, rising edges aligned with clk_in edges, used for select 01 |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Mode select: 00 power-down, 01 doubled, 10 divide by DIV_SLOW, 11 divide by DIV_FAST |
| oe | input | 1 | Output enable, high drives the outputs, low releases them |
| clk_pri | output | 1 | Primary clock output, tri-state |
| clk_sec | output | 1 | Secondary clock output at half the primary rate, tri-state |

## Verification
The bench builds the block with its default ratios, DIV_FAST = 3 and DIV_SLOW = 5. Both slots are therefore odd, which puts the falling-edge stretch path under test in both divide modes. The 3-bit counter must wrap early at 2 in one mode and at 4 in the other. Switching between 3 and 5 at four different phases of the input clock reaches the case where the counter holds a value above the new ratio's last count when the restart begins. Pull-ups on the output nets make the released state visible as a steady high level.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_RESTART = 2'd1,
        ST_RUN_DIV = 2'd2,
        ST_RUN_DBL = 2'd3
    } cd_state_e;

    localparam logic [1:0] SEL_OFF  = 2'b00;
    localparam logic [1:0] SEL_DBL  = 2'b01;
    localparam logic [1:0] SEL_SLOW = 2'b10;
    localparam logic [1:0] SEL_FAST = 2'b11;

endpackage

// File: rtl/clkdiv_mode_fsm.sv
module clkdiv_mode_fsm
    import clkdiv_pkg::*;
(
    input  logic       clk_in,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output cd_state_e  state_o,
    output logic       div_run,
    output logic       dbl_run,
    output logic       pick_slow
);

    cd_state_e  state_q;
    cd_state_e  state_d;
    logic [1:0] code_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (sel == SEL_OFF) begin
            state_d = ST_OFF;                       // sleep
        end else if (sel != code_q) begin
            state_d = ST_RESTART;                   // reload
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = ST_RESTART;
                ST_RESTART: state_d = (code_q == SEL_DBL) ? ST_RUN_DBL : ST_RUN_DIV;
                ST_RUN_DIV: state_d = ST_RUN_DIV;
                ST_RUN_DBL: state_d = ST_RUN_DBL;
                default:    state_d = ST_OFF;
            endcase
        end
    end

    // state register; the last code seen is kept beside it
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            code_q  <= SEL_OFF;
        end else begin
            state_q <= state_d;
            code_q  <= sel;
        end
    end

    // outputs decoded from the current state
    always_comb begin
        div_run = 1'b0;
        dbl_run = 1'b0;
        unique case (state_q)
            ST_OFF:     ;
            ST_RESTART: ;
            ST_RUN_DIV: div_run = 1'b1;
            ST_RUN_DBL: dbl_run = 1'b1;
            default:    ;
        endcase
        pick_slow = (code_q == SEL_SLOW);
    end

    assign state_o = state_q;

endmodule

// File: rtl/clkdiv_odd_core.sv
module clkdiv_odd_core #(
    parameter int RATIO_A = 3,
    parameter int RATIO_B = 5
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic run,
    input  logic pick_b,
    output logic div_out,
    output logic [$clog2((RATIO_A > RATIO_B) ? RATIO_A : RATIO_B)-1:0] cnt_o
);

    localparam int RATIO_MAX = (RATIO_A > RATIO_B) ? RATIO_A : RATIO_B;
    localparam int CNT_W     = $clog2(RATIO_MAX);
    localparam int N_SLOT    = 2;

    logic [CNT_W-1:0] last_v [N_SLOT];
    logic [CNT_W-1:0] thr_v  [N_SLOT];
    logic             odd_v  [N_SLOT];

    // per-slot constants: last count, high threshold, odd flag
    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        localparam int R = (g == 0) ? RATIO_A : RATIO_B;
        assign last_v[g] = CNT_W'(R - 1);
        assign thr_v[g]  = CNT_W'(R / 2);
        assign odd_v[g]  = ((R % 2) == 1);
    end

    logic [CNT_W-1:0] sel_last;
    logic [CNT_W-1:0] sel_thr;
    logic             sel_odd;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             hi_q;
    logic             lo_q;

    assign sel_last = pick_b ? last_v[1] : last_v[0];
    assign sel_thr  = pick_b ? thr_v[1]  : thr_v[0];
    assign sel_odd  = pick_b ? odd_v[1]  : odd_v[0];

    // wraps on >= so a leftover count above a smaller ratio still returns to zero
    assign cnt_nxt = (cnt_q >= sel_last) ? '0 : cnt_q + 1'b1;

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hi_q  <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            hi_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            hi_q  <= (cnt_nxt < sel_thr);
        end
    end

    // half-cycle stretch for odd ratios
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= 1'b0;
        end else begin
            lo_q <= run & sel_odd & hi_q;
        end
    end

    assign div_out = hi_q | lo_q;
    assign cnt_o   = cnt_q;

    AST_CNT_BOUND: assert property (@(posedge clk_in) disable iff (!rst_n)
        run |-> (cnt_q <= sel_last));                                       // R1

    AST_HALF_EXT: assert property (@(posedge clk_in) disable iff (!rst_n)
        (run && sel_odd) |-> (lo_q == hi_q));                               // R10

endmodule

// File: rtl/clkdiv_half_stage.sv
module clkdiv_half_stage (
    input  logic pri_in,
    input  logic clr_n,
    output logic sec_out
);

    logic sec_q;

    always_ff @(posedge pri_in or negedge clr_n) begin
        if (!clr_n) begin
            sec_q <= 1'b0;
        end else begin
            sec_q <= ~sec_q;
        end
    end

    assign sec_out = sec_q;

endmodule

// File: rtl/clkdiv_pair.sv
module clkdiv_pair
    import clkdiv_pkg::*;
#(
    parameter int DIV_FAST = 3,
    parameter int DIV_SLOW = 5
) (
    input  logic       clk_in,
    input  logic       clk_2x_in,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       oe,
    output wire        clk_pri,
    output wire        clk_sec
);

    localparam int RATIO_MAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
    localparam int CNT_W     = $clog2(RATIO_MAX);

    cd_state_e        state;
    logic             div_run;
    logic             dbl_run;
    logic             pick_slow;
    logic             div_pri;
    logic [CNT_W-1:0] cnt;
    logic             dbl_gate_q;
    logic             pri_int;
    logic             sec_int;
    logic             sec_clr_n;

    clkdiv_mode_fsm u_fsm (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .sel       (sel),
        .state_o   (state),
        .div_run   (div_run),
        .dbl_run   (dbl_run),
        .pick_slow (pick_slow)
    );

    clkdiv_odd_core #(
        .RATIO_A (DIV_FAST),
        .RATIO_B (DIV_SLOW)
    ) u_core (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .run     (div_run),
        .pick_b  (pick_slow),
        .div_out (div_pri),
        .cnt_o   (cnt)
    );

    // gate enable moves only while the doubled clock is low
    always_ff @(negedge clk_2x_in or negedge rst_n) begin
        if (!rst_n) begin
            dbl_gate_q <= 1'b0;
        end else begin
            dbl_gate_q <= dbl_run;
        end
    end

    assign pri_int   = div_pri | (clk_2x_in & dbl_gate_q);
    assign sec_clr_n = rst_n & (div_run | dbl_run);

    clkdiv_half_stage u_half (
        .pri_in  (pri_int),
        .clr_n   (sec_clr_n),
        .sec_out (sec_int)
    );

    assign clk_pri = oe ? pri_int : 1'bz;
    assign clk_sec = oe ? sec_int : 1'bz;

    AST_PD_QUIET: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state == ST_OFF && $past(state) == ST_OFF && $past(state, 2) == ST_OFF)
        |-> (!pri_int && !sec_int));                                        // R6

    AST_RESTART_CLEAR: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state == ST_RESTART) |=> (cnt == '0));                             // R8

endmodule

// File: tb/clkdiv_pair_tb_top.sv
`timescale 1ns/1ps
module clkdiv_pair_tb_top;

    localparam int CLK_PERIOD = 20;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int QTR        = CLK_PERIOD / 4;

    // {sel, pri period, pri high, sec period, sec high} in ns
    localparam int N_VEC = 4;
    localparam int VEC [N_VEC][5] = '{
        '{3,  60, 30, 120,  60},
        '{2, 100, 50, 200, 100},
        '{1,  10,  5,  20,  10},
        '{3,  60, 30, 120,  60}
    };

    logic       clk_in;
    logic       clk_2x;
    logic       rst_n;
    logic       oe;
    logic [1:0] sel;
    wire        pri_w;
    wire        sec_w;

    pullup pu_pri (pri_w);
    pullup pu_sec (sec_w);

    int checks = 0;
    int fails  = 0;

    clkdiv_pair dut_i (
        .clk_in    (clk_in),
        .clk_2x_in (clk_2x),
        .rst_n     (rst_n),
        .sel       (sel),
        .oe        (oe),
        .clk_pri   (pri_w),
        .clk_sec   (sec_w)
    );

    initial begin
        clk_in = 1'b1;
        forever #(HALF) clk_in = ~clk_in;
    end

    initial begin
        clk_2x = 1'b1;
        forever #(QTR) clk_2x = ~clk_2x;
    end

    time pri_last_rise = 0;
    always @(posedge pri_w) pri_last_rise = $time;

    bit  watch     = 1'b0;
    time last_edge = 0;
    time min_w     = 0;
    always @(pri_w) begin
        if (watch && (($time - last_edge) < min_w)) min_w = $time - last_edge;
        last_edge = $time;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure(input bit use_sec, output longint per, output longint hi);
        time t0, t1, t2;
        if (use_sec) begin
            @(posedge sec_w); t0 = $time;
            @(negedge sec_w); t1 = $time;
            @(posedge sec_w); t2 = $time;
        end else begin
            @(posedge pri_w); t0 = $time;
            @(negedge pri_w); t1 = $time;
            @(posedge pri_w); t2 = $time;
        end
        per = longint'(t2 - t0);
        hi  = longint'(t1 - t0);
    endtask

    task automatic check_align();
        bit     ok  = 1'b1;
        longint gap = 0;
        for (int k = 0; k < 4; k++) begin
            @(sec_w);
            #1;
            if (pri_last_rise != $time - 1) begin
                ok  = 1'b0;
                gap = longint'($time - 1 - pri_last_rise);
            end
        end
        chk(ok, "R4", gap, 0);
    endtask

    task automatic sample_level(input int n, input logic lvl, input string req);
        bit     ok  = 1'b1;
        longint act = lvl;
        for (int k = 0; k < n; k++) begin
            @(posedge clk_in);
            #3;
            if (pri_w !== lvl || sec_w !== lvl) begin ok = 1'b0; act = {pri_w, sec_w}; end
            #10;
            if (pri_w !== lvl || sec_w !== lvl) begin ok = 1'b0; act = {pri_w, sec_w}; end
        end
        chk(ok, req, act, lvl);
    endtask

    task automatic settle_sel(input logic [1:0] code);
        @(posedge clk_in);
        #3;
        sel = code;
        repeat (12) @(posedge clk_in);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        longint per, hi;
        string  req;
        rst_n = 1'b0;
        oe    = 1'b1;
        sel   = 2'b11;

        // R9: outputs low under reset
        repeat (3) @(posedge clk_in);
        #3;
        chk(pri_w === 1'b0 && sec_w === 1'b0, "R9", {pri_w, sec_w}, 0);
        @(negedge clk_in);
        #2;
        rst_n = 1'b1;

        // table walk: R1 R2 R5 R3 R4 R10
        for (int i = 0; i < N_VEC; i++) begin
            settle_sel(2'(VEC[i][0]));
            req = (VEC[i][0] == 3) ? "R1" : (VEC[i][0] == 2) ? "R2" : "R5";
            measure(1'b0, per, hi);
            chk(per == VEC[i][1], req, per, VEC[i][1]);
            chk(hi == VEC[i][2], req, hi, VEC[i][2]);
            if (VEC[i][0] != 1) begin
                chk(hi * 100 >= per * 45 && hi * 100 <= per * 55, "R10", (hi * 100) / per, 50);
            end
            measure(1'b1, per, hi);
            chk(per == VEC[i][3], "R3", per, VEC[i][3]);
            chk(hi == VEC[i][4], "R3", hi, VEC[i][4]);
            check_align();
        end

        // R8: switch 3 <-> 5 at several phases, no runt pulses
        for (int off = 0; off < 4; off++) begin
            @(posedge clk_in);
            #(3 + off * 4 + ((off > 1) ? 2 : 0));
            min_w = 1000;
            watch = 1'b1;
            sel   = (sel == 2'b11) ? 2'b10 : 2'b11;
            repeat (14) @(posedge clk_in);
            watch = 1'b0;
            chk(min_w >= HALF, "R8", longint'(min_w), HALF);
        end
        measure(1'b0, per, hi);
        chk(per == ((sel == 2'b11) ? 60 : 100), "R8", per, (sel == 2'b11) ? 60 : 100);

        // R6: power-down holds both low, then resumes
        @(posedge clk_in);
        #3;
        sel = 2'b00;
        repeat (4) @(posedge clk_in);
        sample_level(30, 1'b0, "R6");
        settle_sel(2'b11);
        measure(1'b0, per, hi);
        chk(per == 60, "R6", per, 60);

        // R7: released outputs read the pull-up level, running and powered down
        @(posedge clk_in);
        #3;
        oe = 1'b0;
        sample_level(30, 1'b1, "R7");
        @(posedge clk_in);
        #3;
        sel = 2'b00;
        sample_level(20, 1'b1, "R7");
        @(posedge clk_in);
        #3;
        oe = 1'b1;
        settle_sel(2'b10);
        measure(1'b0, per, hi);
        chk(per == 100, "R7", per, 100);

        // R9: asynchronous reset in mid-run
        settle_sel(2'b11);
        @(posedge pri_w);
        #3;
        rst_n = 1'b0;
        #1;
        chk(pri_w === 1'b0 && sec_w === 1'b0, "R9", {pri_w, sec_w}, 0);
        sample_level(3, 1'b0, "R9");
        @(negedge clk_in);
        #2;
        rst_n = 1'b1;
        repeat (12) @(posedge clk_in);
        measure(1'b0, per, hi);
        chk(per == 60 && hi == 30, "R9", per, 60);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule